// File: doc/BRIEF.md
# Hierarchical Macroblock Address Generator

This block produces frame-memory addresses for two-dimensional video test data. The data is held as a stack of frames in CIF luma size (352 by 288 pixels). Each frame is made of 16x16-pixel macroblocks, each macroblock of 8x8-pixel blocks, and each block of single pixels. The block keeps a reference position as separate X and Y coordinates (macroblock, block and pixel) plus a frame number. A command can load that reference outright or move it by signed steps.

A burst command gives a loop count for macroblocks, blocks and pixels in each axis. Six nested counters then walk those counts and give an X and a Y offset. Two separate adders add the offsets to the reference. The X and Y sums are then folded with the frame number into one linear address. One address leaves per clock, tagged with the burst's read or write flag. Two scan orders are offered: row order sweeps X first, column order sweeps Y first. A single-cycle done pulse follows the last address. Commands that arrive during a burst are dropped.

Top module: `mb_addr_gen`

## Requirements
- R1: After reset, out_valid, out_wr and done are low and the reference position is all zero, so a burst with all counts zero yields address 0.
- R2: A command with cmd_op = 0 (set) loads the frame number and the X and Y macroblock, block and pixel coordinates from the command fields. The pixel coordinate is the low 3 bits of its field and the block coordinate is bit 0 of its field. Absolute X is mb*16 + block*8 + pixel, and absolute Y is formed the same way.
- R3: A command with cmd_op = 1 (step) adds each command field, read as two's complement, to its own reference field with no carry between fields. The pixel wraps modulo 8, the block modulo 2, the X macroblock modulo 22, the Y macroblock modulo 18 and the frame modulo the frame count.
- R4: A command with cmd_op = 2 (burst) uses the low 3 bits of each pixel field, bit 0 of each block field and the full macroblock fields as counts. A count n gives n+1 steps at that level. The burst yields exactly the product of all six step counts in addresses.
- R5: With cmd_col = 0 the scan order, from fastest to slowest, is X pixel, X block, X macroblock, Y pixel, Y block, Y macroblock.
- R6: With cmd_col = 1 the scan order, from fastest to slowest, is Y pixel, Y block, Y macroblock, X pixel, X block, X macroblock.
- R7: The addresses of one burst appear on consecutive cycles with out_valid high. out_wr equals the burst's cmd_wr on every one of them and is low when out_valid is low.
- R8: done is high for exactly one cycle, the cycle right after the last address of a burst, and out_valid is low in that cycle.
- R9: A command of any kind that arrives while a burst is running is ignored. It does not change the reference position and it does not change the running burst.
- R10: Each address equals frame*101376 + (refY + offY)*352 + (refX + offX). The offsets are mb_count_index*16 + block_index*8 + pixel_index in each axis. Offsets are not wrapped at the frame edge.
- R11: A cmd_op of 3 is no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 set, 1 step, 2 burst, 3 none |
| cmd_col | input | 1 | Burst scan order: 0 row first, 1 column first |
| cmd_wr | input | 1 | Burst direction: 1 write, 0 read |
| cmd_frame | input | 2 | Frame value or frame step |
| cmd_mbx | input | 5 | X macroblock value, step or count |
| cmd_bx | input | 2 | X block value, step or count |
| cmd_px | input | 4 | X pixel value, step or count |
| cmd_mby | input | 5 | Y macroblock value, step or count |
| cmd_by | input | 2 | Y block value, step or count |
| cmd_py | input | 4 | Y pixel value, step or count |
| out_valid | output | 1 | Address present this cycle |
| out_wr | output | 1 | Write flag of the present address |
| out_addr | output | 20 | Linear frame-memory address |
| done | output | 1 | One-cycle pulse after the last address |

## Verification
Full-block bursts are run in both scan orders from the same reference. Row-first and column-first walks cover the same addresses, so only the order of the addresses tells them apart. Bursts that cross block and macroblock edges show whether the offset weights of 8 and 16 are right. A single-pixel burst after each set or step exposes the reference alone, so it checks each field's wrap on its own, including backward steps. Commands injected during a burst, followed by a probe burst, show whether the reference and the running walk were left untouched. Seeded random mixes of set, step and small bursts then cross all of these.

// File: rtl/mbag_pkg.sv
package mbag_pkg;
    localparam int FRM_W     = 2;
    localparam int FRAMES    = 1 << FRM_W;
    localparam int MB_W      = 5;
    localparam int BLK_W     = 2;
    localparam int PIX_W     = 4;
    localparam int MB_COLS   = 22;
    localparam int MB_ROWS   = 18;
    localparam int LINE_PIX  = MB_COLS * 16;
    localparam int ROW_PIX   = MB_ROWS * 16;
    localparam int FRAME_PIX = LINE_PIX * ROW_PIX;
    localparam int ADDR_W    = $clog2(FRAMES * FRAME_PIX) + 1;
    localparam int CRD_W     = MB_W + 4;
    localparam int ABS_W     = CRD_W + 1;
    localparam int NAXIS     = 2;

    typedef enum logic [1:0] {
        OP_SET   = 2'd0,
        OP_STEP  = 2'd1,
        OP_BURST = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef struct packed {
        logic [FRM_W-1:0] frame;
        logic [MB_W-1:0]  mbx;
        logic [BLK_W-1:0] bx;
        logic [PIX_W-1:0] px;
        logic [MB_W-1:0]  mby;
        logic [BLK_W-1:0] by;
        logic [PIX_W-1:0] py;
    } fields_t;

    typedef struct packed {
        logic [FRM_W-1:0] frame;
        logic [MB_W-1:0]  mbx;
        logic             bx;
        logic [2:0]       px;
        logic [MB_W-1:0]  mby;
        logic             by;
        logic [2:0]       py;
    } pos_t;

    // mb*16 + blk*8 + pix is a plain bit concatenation
    function automatic logic [CRD_W-1:0] coord(input logic [MB_W-1:0] mb,
                                               input logic b,
                                               input logic [2:0] p);
        return {mb, b, p};
    endfunction

    // signed step of a macroblock index, wrapped into [0, lim)
    function automatic logic [MB_W-1:0] wrap_mb(input logic [MB_W-1:0] cur,
                                                input logic [MB_W-1:0] d,
                                                input logic signed [MB_W+1:0] lim);
        logic signed [MB_W+1:0] s;
        s = $signed({2'b00, cur}) + $signed({{2{d[MB_W-1]}}, d});
        if (s < 0)
            s = s + lim;
        else if (s >= lim)
            s = s - lim;
        return s[MB_W-1:0];
    endfunction
endpackage

// File: rtl/mbag_ref.sv
module mbag_ref
    import mbag_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    set_en,
    input  logic    step_en,
    input  fields_t f,
    output pos_t    pos
);
    localparam logic signed [MB_W+1:0] LIM_X = (MB_W+2)'(MB_COLS);
    localparam logic signed [MB_W+1:0] LIM_Y = (MB_W+2)'(MB_ROWS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (set_en) begin
            pos.frame <= f.frame;
            pos.mbx   <= f.mbx;
            pos.bx    <= f.bx[0];
            pos.px    <= f.px[2:0];
            pos.mby   <= f.mby;
            pos.by    <= f.by[0];
            pos.py    <= f.py[2:0];
        end else if (step_en) begin
            pos.frame <= pos.frame + f.frame;
            pos.mbx   <= wrap_mb(pos.mbx, f.mbx, LIM_X);
            pos.bx    <= pos.bx ^ f.bx[0];
            pos.px    <= pos.px + f.px[2:0];
            pos.mby   <= wrap_mb(pos.mby, f.mby, LIM_Y);
            pos.by    <= pos.by ^ f.by[0];
            pos.py    <= pos.py + f.py[2:0];
        end
    end
endmodule

// File: rtl/mbag_axis.sv
module mbag_axis
    import mbag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [MB_W-1:0]  lim_mb,
    input  logic             lim_b,
    input  logic [2:0]       lim_p,
    output logic [CRD_W-1:0] off,
    output logic             last
);
    logic [MB_W-1:0] mb_q;
    logic            b_q;
    logic [2:0]      p_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            mb_q <= '0;
            b_q  <= 1'b0;
            p_q  <= '0;
        end else if (step) begin
            if (p_q == lim_p) begin
                p_q <= '0;
                if (b_q == lim_b) begin
                    b_q  <= 1'b0;
                    mb_q <= (mb_q == lim_mb) ? '0 : mb_q + 1'b1;
                end else begin
                    b_q <= 1'b1;
                end
            end else begin
                p_q <= p_q + 1'b1;
            end
        end
    end

    assign last = (mb_q == lim_mb) && (b_q == lim_b) && (p_q == lim_p);
    assign off  = coord(mb_q, b_q, p_q);
endmodule

// File: rtl/mb_addr_gen.sv
module mb_addr_gen
    import mbag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_col,
    input  logic              cmd_wr,
    input  logic [FRM_W-1:0]  cmd_frame,
    input  logic [MB_W-1:0]   cmd_mbx,
    input  logic [BLK_W-1:0]  cmd_bx,
    input  logic [PIX_W-1:0]  cmd_px,
    input  logic [MB_W-1:0]   cmd_mby,
    input  logic [BLK_W-1:0]  cmd_by,
    input  logic [PIX_W-1:0]  cmd_py,
    output logic              out_valid,
    output logic              out_wr,
    output logic [ADDR_W-1:0] out_addr,
    output logic              done
);
    fields_t f;
    pos_t    pos;
    op_e     op;
    logic    accept, busy, col_q, wr_q, end_q, burst_end;

    logic [MB_W-1:0]  lim_mb [NAXIS];
    logic             lim_b  [NAXIS];
    logic [2:0]       lim_p  [NAXIS];
    logic [CRD_W-1:0] off    [NAXIS];
    logic [CRD_W-1:0] refc   [NAXIS];
    logic [ABS_W-1:0] absc   [NAXIS];
    logic             last   [NAXIS];
    logic             step   [NAXIS];

    assign f      = '{frame: cmd_frame, mbx: cmd_mbx, bx: cmd_bx, px: cmd_px,
                      mby: cmd_mby, by: cmd_by, py: cmd_py};
    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid && !busy;

    mbag_ref u_ref (
        .clk     (clk),
        .rst     (rst),
        .set_en  (accept && op == OP_SET),
        .step_en (accept && op == OP_STEP),
        .f       (f),
        .pos     (pos)
    );

    assign refc[0] = coord(pos.mbx, pos.bx, pos.px);
    assign refc[1] = coord(pos.mby, pos.by, pos.py);

    // row order: X runs every cycle, Y advances on X wrap; column swaps them
    assign step[0] = busy && (col_q ? last[1] : 1'b1);
    assign step[1] = busy && (col_q ? 1'b1 : last[0]);

    generate
        for (genvar a = 0; a < NAXIS; a++) begin : g_axis
            mbag_axis u_axis (
                .clk    (clk),
                .rst    (rst),
                .load   (accept && op == OP_BURST),
                .step   (step[a]),
                .lim_mb (lim_mb[a]),
                .lim_b  (lim_b[a]),
                .lim_p  (lim_p[a]),
                .off    (off[a]),
                .last   (last[a])
            );
            assign absc[a] = {1'b0, refc[a]} + {1'b0, off[a]};
        end
    endgenerate

    assign burst_end = busy && last[0] && last[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            col_q <= 1'b0;
            wr_q  <= 1'b0;
            for (int a = 0; a < NAXIS; a++) begin
                lim_mb[a] <= '0;
                lim_b[a]  <= 1'b0;
                lim_p[a]  <= '0;
            end
        end else if (accept && op == OP_BURST) begin
            busy      <= 1'b1;
            col_q     <= cmd_col;
            wr_q      <= cmd_wr;
            lim_mb[0] <= cmd_mbx;
            lim_b[0]  <= cmd_bx[0];
            lim_p[0]  <= cmd_px[2:0];
            lim_mb[1] <= cmd_mby;
            lim_b[1]  <= cmd_by[0];
            lim_p[1]  <= cmd_py[2:0];
        end else if (burst_end) begin
            busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_wr    <= 1'b0;
            out_addr  <= '0;
            end_q     <= 1'b0;
            done      <= 1'b0;
        end else begin
            out_valid <= busy;
            out_wr    <= busy && wr_q;
            out_addr  <= ADDR_W'(pos.frame) * ADDR_W'(FRAME_PIX)
                       + ADDR_W'(absc[1]) * ADDR_W'(LINE_PIX)
                       + ADDR_W'(absc[0]);
            end_q     <= burst_end;
            done      <= out_valid && end_q;
        end
    end
endmodule

// File: rtl/mb_addr_gen_chk.sv
module mb_addr_gen_chk
    import mbag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_wr,
    input logic [ADDR_W-1:0] out_addr,
    input logic              done
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && !done && !out_wr);

    // R7
    wr_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_wr);

    // R7
    wr_steady_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) |-> $stable(out_wr));

    // R8
    done_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_valid) && !out_valid);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    addr_known_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_addr));
endmodule

bind mb_addr_gen mb_addr_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_wr    (out_wr),
    .out_addr  (out_addr),
    .done      (done)
);

// File: tb/mb_addr_gen_test.sv
module mb_addr_gen_test;
    import mbag_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BURST_LIMIT = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd3;
    logic              cmd_col = 1'b0;
    logic              cmd_wr = 1'b0;
    logic [FRM_W-1:0]  cmd_frame = '0;
    logic [MB_W-1:0]   cmd_mbx = '0;
    logic [BLK_W-1:0]  cmd_bx = '0;
    logic [PIX_W-1:0]  cmd_px = '0;
    logic [MB_W-1:0]   cmd_mby = '0;
    logic [BLK_W-1:0]  cmd_by = '0;
    logic [PIX_W-1:0]  cmd_py = '0;
    logic              out_valid, out_wr, done;
    logic [ADDR_W-1:0] out_addr;

    mb_addr_gen uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_col(cmd_col), .cmd_wr(cmd_wr), .cmd_frame(cmd_frame),
        .cmd_mbx(cmd_mbx), .cmd_bx(cmd_bx), .cmd_px(cmd_px),
        .cmd_mby(cmd_mby), .cmd_by(cmd_by), .cmd_py(cmd_py),
        .out_valid(out_valid), .out_wr(out_wr), .out_addr(out_addr), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    // bench model of the reference position
    int rf = 0, rmx = 0, rbx = 0, rpx = 0, rmy = 0, rby = 0, rpy = 0;
    int exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int sx(input int v, input int w);
        return (v >= (1 << (w-1))) ? v - (1 << w) : v;
    endfunction

    function automatic int lin(input int fr, input int x, input int y);
        return (fr * FRAME_PIX + y * LINE_PIX + x) % (1 << ADDR_W);
    endfunction

    task automatic put_cmd(input int op, input int col, input int wr, input int fr,
                           input int mx, input int bx, input int px,
                           input int my, input int by, input int py);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_col   = 1'(col);
        cmd_wr    = 1'(wr);
        cmd_frame = FRM_W'(fr);
        cmd_mbx   = MB_W'(mx);
        cmd_bx    = BLK_W'(bx);
        cmd_px    = PIX_W'(px);
        cmd_mby   = MB_W'(my);
        cmd_by    = BLK_W'(by);
        cmd_py    = PIX_W'(py);
    endtask

    task automatic do_set(input int fr, input int mx, input int bx, input int px,
                          input int my, input int by, input int py);
        put_cmd(0, 0, 0, fr, mx, bx, px, my, by, py);
        @(negedge clk);
        cmd_valid = 1'b0;
        rf = fr; rmx = mx; rbx = bx & 1; rpx = px & 7;
        rmy = my; rby = by & 1; rpy = py & 7;
    endtask

    task automatic do_step(input int fr, input int mx, input int bx, input int px,
                           input int my, input int by, input int py);
        put_cmd(1, 0, 0, fr, mx, bx, px, my, by, py);
        @(negedge clk);
        cmd_valid = 1'b0;
        rf  = (rf + fr) % FRAMES;
        rmx = ((rmx + sx(mx, MB_W)) % MB_COLS + MB_COLS) % MB_COLS;
        rbx = (rbx + sx(bx, BLK_W)) & 1;
        rpx = (rpx + sx(px, PIX_W)) & 7;
        rmy = ((rmy + sx(my, MB_W)) % MB_ROWS + MB_ROWS) % MB_ROWS;
        rby = (rby + sx(by, BLK_W)) & 1;
        rpy = (rpy + sx(py, PIX_W)) & 7;
    endtask

    // R5 / R6 / R10: expected addresses in scan order
    task automatic build_exp(input int col, input int cmx, input int cbx, input int cpx,
                             input int cmy, input int cby, input int cpy);
        int ox[$];
        int oy[$];
        int rx, ry;
        exp_q.delete();
        rx = rmx * 16 + rbx * 8 + rpx;
        ry = rmy * 16 + rby * 8 + rpy;
        for (int m = 0; m <= cmx; m++)
            for (int b = 0; b <= (cbx & 1); b++)
                for (int p = 0; p <= (cpx & 7); p++)
                    ox.push_back(m * 16 + b * 8 + p);
        for (int m = 0; m <= cmy; m++)
            for (int b = 0; b <= (cby & 1); b++)
                for (int p = 0; p <= (cpy & 7); p++)
                    oy.push_back(m * 16 + b * 8 + p);
        if (col == 0) begin
            foreach (oy[j]) foreach (ox[i]) exp_q.push_back(lin(rf, rx + ox[i], ry + oy[j]));
        end else begin
            foreach (ox[i]) foreach (oy[j]) exp_q.push_back(lin(rf, rx + ox[i], ry + oy[j]));
        end
    endtask

    task automatic do_burst(input string req, input int col, input int wr,
                            input int cmx, input int cbx, input int cpx,
                            input int cmy, input int cby, input int cpy,
                            input bit inject);
        int idx = 0, bad = 0, first_bad = -1, wr_bad = 0, gap = 0, cyc = 0;
        bit prev = 0, seen_done = 0, done_ok = 0;
        build_exp(col, cmx, cbx, cpx, cmy, cby, cpy);
        put_cmd(2, col, wr, 0, cmx, cbx, cpx, cmy, cby, cpy);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!seen_done && cyc < BURST_LIMIT) begin
            @(negedge clk);
            cyc++;
            cmd_valid = 1'b0;
            if (out_valid) begin
                if (idx < exp_q.size() && int'(out_addr) != exp_q[idx]) begin
                    bad++;
                    if (first_bad < 0) first_bad = idx;
                end
                if (out_wr != 1'(wr)) wr_bad++;
                idx++;
                if (inject && idx == 3)
                    put_cmd($urandom_range(0, 2), 1 - col, 1 - wr, 1, 3, 1, 5, 2, 0, 6);
            end else if (prev && !done) begin
                gap++;
            end
            if (done) begin
                seen_done = 1;
                done_ok = prev && !out_valid;
            end
            prev = out_valid;
        end
        cmd_valid = 1'b0;
        if (cyc >= BURST_LIMIT)
            chk(0, "R8", "burst never finished (timeout)", cyc, exp_q.size() + 1);
        chk(first_bad < 0, req, "address mismatches",
            bad, 0);
        if (first_bad >= 0)
            $display("  first mismatch at beat %0d expected=%0d", first_bad, exp_q[first_bad]);
        chk(idx == exp_q.size(), "R4", "address count", idx, exp_q.size());
        chk(wr_bad == 0 && gap == 0, "R7", "wr flag errors plus gaps", wr_bad + gap, 0);
        chk(done_ok, "R8", "done right after last address", done_ok, 1);
        @(negedge clk);
        chk(!done, "R8", "done lasts one cycle", done, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!out_valid && !done && !out_wr, "R1", "outputs during reset",
            {out_valid, done, out_wr}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !done, "R1", "outputs after reset", {out_valid, done}, 0);
        do_burst("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R11: no-op command leaves the reference at zero
        put_cmd(3, 0, 0, 1, 4, 1, 3, 2, 1, 5);
        @(negedge clk);
        cmd_valid = 1'b0;
        do_burst("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        do_set(1, 5, 1, 0, 4, 1, 0);
        do_burst("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_burst("R5", 0, 0, 0, 0, 7, 0, 0, 7, 0);
        do_burst("R6", 1, 1, 0, 0, 7, 0, 0, 7, 0);
        do_burst("R10", 0, 1, 1, 1, 7, 0, 1, 2, 0);
        do_burst("R6", 1, 0, 1, 1, 3, 1, 0, 2, 0);

        // R3: backward macroblock wrap, block and pixel wrap, frame back to 0
        do_set(1, 5, 1, 0, 2, 0, 7);
        do_step(3, 32 - 7, 1, 15, 32 - 4, 3, 1);
        do_burst("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_step(0, 3, 0, 9, 16, 1, 8);
        do_burst("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R9: command during a burst is dropped
        do_set(2, 10, 0, 3, 7, 1, 2);
        do_burst("R9", 0, 1, 0, 1, 7, 0, 0, 3, 1);
        do_burst("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_burst("R9", 1, 0, 0, 0, 7, 0, 1, 3, 1);
        do_burst("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        for (int it = 0; it < 40; it++) begin
            int kind;
            kind = $urandom_range(0, 2);
            if (kind == 0)
                do_set($urandom_range(0, FRAMES-1), $urandom_range(0, MB_COLS-1),
                       $urandom_range(0, 1), $urandom_range(0, 7),
                       $urandom_range(0, MB_ROWS-1), $urandom_range(0, 1),
                       $urandom_range(0, 7));
            else if (kind == 1)
                do_step($urandom_range(0, FRAMES-1), $urandom_range(0, 31),
                        $urandom_range(0, 3), $urandom_range(0, 15),
                        $urandom_range(0, 31), $urandom_range(0, 3),
                        $urandom_range(0, 15));
            else begin
                int col;
                col = $urandom_range(0, 1);
                do_burst(col ? "R6" : "R5", col, $urandom_range(0, 1),
                         $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 15),
                         $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 15),
                         1'($urandom_range(0, 1)));
            end
            do_burst("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog expired: actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule